// File: doc/BRIEF.md
# Handshaked Micropipeline FIFO Controller

This block is a first-in first-out buffer whose flow control comes from a chain of state cells rather than from pointers and occupancy counters. Each stage has one cell that behaves like a Muller C-element. Its state is held in a flop and advances once per clock. The cell's two inputs are the request from the stage before it and the inverted acknowledge from the stage after it. When the cell rises, it opens its stage's data register for one cycle. The token's data therefore travels down the chain together with its request.

The producer uses a four-phase return-to-zero handshake on `in_req`/`in_ack`: it raises the request, waits for the acknowledge, drops the request, and waits for the acknowledge to drop. The consumer sees the same four-phase pattern on `out_req`/`out_ack`. The first cell's state is `in_ack`, and the last cell's state is `out_req`.

Each cell has two states, `CEL_LOW` and `CEL_HIGH`. It takes one of three transitions:
- RISE (`CEL_LOW`→`CEL_HIGH`) when the request from the previous stage is high and the acknowledge from the next stage is low.
- FALL (`CEL_HIGH`→`CEL_LOW`) when the request is low and the acknowledge is high.
- HOLD in every other case.

Top module: `mpf_ctrl`

## Requirements
- R1: While and directly after a synchronous active-high reset, every cell is in `CEL_LOW`, so `in_ack` and `out_req` are 0 and `out_data` is 0.
- R2: Each cell follows the C-element rule on (previous request, inverted next acknowledge). It rises when both are 1, falls when both are 0, and holds otherwise. Each cell updates once per clock edge.
- R3: `in_ack` rises only at an edge where `in_req` was high, and falls only at an edge where `in_req` was low.
- R4: `out_req` rises only at an edge where `out_ack` was low, and falls only at an edge where `out_ack` was high. While `out_ack` stays low, `out_req` never drops.
- R5: With an empty chain and `out_ack` low, `in_ack` is high after the first edge that samples `in_req` high. `out_req` is high after edge number STAGES, counted from that same edge.
- R6: `out_data` does not change while `out_req` stays high. It equals the data of the token being offered.
- R7: Tokens leave in the order they entered, with none lost or repeated, under any pattern of consumer stalls. Input data only needs to be held until `in_ack` rises.
- R8: With `out_ack` held low from an empty state, the chain accepts exactly (STAGES+1)/2 tokens (integer division), after which `in_ack` stays low while `in_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Producer request |
| in_ack | output | 1 | Acknowledge to producer (first cell state) |
| in_data | input | WIDTH | Producer data, valid from in_req rise to in_ack rise |
| out_req | output | 1 | Request to consumer (last cell state) |
| out_ack | input | 1 | Consumer acknowledge |
| out_data | output | WIDTH | Data of the token offered to the consumer |

## Verification
On every cycle, the checker enforces the per-cell C-element rule, the ordering of both handshakes, the reset state, and the stability of the offered data. Latency, the number of tokens the chain holds when stalled, and the order and integrity of a long token stream under irregular consumer stalls depend on data history. Only the bench's scenarios can show these.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic {
        CEL_LOW  = 1'b0,
        CEL_HIGH = 1'b1
    } cel_state_e;

    typedef enum logic [1:0] {
        TR_HOLD = 2'd0,
        TR_RISE = 2'd1,
        TR_FALL = 2'd2
    } cel_trans_e;

endpackage

// File: rtl/mpf_ccell.sv
module mpf_ccell
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_prev,
    input  logic ack_next,
    output logic c_out,
    output logic fire
);

    cel_state_e state_q;
    cel_state_e state_d;
    cel_trans_e trans;

    // next-state selection
    always_comb begin
        state_d = state_q;
        trans   = TR_HOLD;
        unique case (state_q)
            CEL_LOW: begin
                if (req_prev && !ack_next) begin
                    state_d = CEL_HIGH;
                    trans   = TR_RISE;
                end
            end
            CEL_HIGH: begin
                if (!req_prev && ack_next) begin
                    state_d = CEL_LOW;
                    trans   = TR_FALL;
                end
            end
            default: begin
                state_d = CEL_LOW;
                trans   = TR_HOLD;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CEL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        c_out = (state_q == CEL_HIGH);
        fire  = (trans == TR_RISE);
    end

endmodule

// File: rtl/mpf_dreg.sv
module mpf_dreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mpf_ctrl.sv
module mpf_ctrl #(
    parameter int STAGES = 4,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_req,
    output logic             in_ack,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_req,
    input  logic             out_ack,
    output logic [WIDTH-1:0] out_data
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cstate;
    logic [STAGES-1:0] load;
    logic [STAGES-1:0] req_in_v;
    logic [STAGES-1:0] ack_in_v;
    logic [WIDTH-1:0]  dq [STAGES];
    logic [WIDTH-1:0]  dsrc [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign req_in_v[g] = in_req;
                assign dsrc[g]     = in_data;
            end else begin : g_body
                assign req_in_v[g] = cstate[g-1];
                assign dsrc[g]     = dq[g-1];
            end

            if (g == LAST) begin : g_tail
                assign ack_in_v[g] = out_ack;
            end else begin : g_mid
                assign ack_in_v[g] = cstate[g+1];
            end

            mpf_ccell u_cell (
                .clk      (clk),
                .rst      (rst),
                .req_prev (req_in_v[g]),
                .ack_next (ack_in_v[g]),
                .c_out    (cstate[g]),
                .fire     (load[g])
            );

            mpf_dreg #(.WIDTH(WIDTH)) u_dreg (
                .clk  (clk),
                .rst  (rst),
                .load (load[g]),
                .d    (dsrc[g]),
                .q    (dq[g])
            );
        end
    endgenerate

    assign in_ack   = cstate[0];
    assign out_req  = cstate[LAST];
    assign out_data = dq[LAST];

endmodule

// File: rtl/mpf_ctrl_chk.sv
module mpf_ctrl_chk #(
    parameter int STAGES = 4,
    parameter int WIDTH  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_req,
    input logic              in_ack,
    input logic              out_req,
    input logic              out_ack,
    input logic [WIDTH-1:0]  out_data,
    input logic [STAGES-1:0] cstate
);

    logic [STAGES-1:0] prv;
    logic [STAGES-1:0] nxt;

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            prv[i] = (i == 0) ? in_req : cstate[(i == 0) ? 0 : i-1];
            nxt[i] = (i == STAGES-1) ? out_ack : cstate[(i == STAGES-1) ? i : i+1];
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (!in_ack && !out_req && out_data == '0));

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_cell_chk
            assert_cel_rise_R2: assert property (@(posedge clk) disable iff (rst)
                (prv[g] && !nxt[g]) |=> cstate[g]);
            assert_cel_fall_R2: assert property (@(posedge clk) disable iff (rst)
                (!prv[g] && nxt[g]) |=> !cstate[g]);
            assert_cel_hold_R2: assert property (@(posedge clk) disable iff (rst)
                (prv[g] == nxt[g]) |=> (cstate[g] == $past(cstate[g])));
        end
    endgenerate

    assert_in_ack_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ack) |-> $past(in_req));
    assert_in_ack_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ack) |-> !$past(in_req));

    assert_out_req_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> !$past(out_ack));
    assert_out_req_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(out_req) |-> $past(out_ack));
    assert_out_req_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> out_req);

    assert_out_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_req && $past(out_req)) |-> $stable(out_data));

endmodule

bind mpf_ctrl mpf_ctrl_chk #(.STAGES(STAGES), .WIDTH(WIDTH)) u_mpf_ctrl_chk (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data),
    .cstate   (cstate)
);

// File: tb/mpf_ctrl_bench.sv
`timescale 1ns/1ps
module mpf_ctrl_bench;

    localparam int STAGES = 4;
    localparam int WIDTH  = 8;
    localparam int CAP    = (STAGES + 1) / 2;
    localparam int NSTREAM = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_req = 1'b0;
    logic             in_ack;
    logic [WIDTH-1:0] in_data = '0;
    logic             out_req;
    logic             out_ack = 1'b0;
    logic [WIDTH-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mpf_ctrl #(.STAGES(STAGES), .WIDTH(WIDTH)) u_mpf_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_req   (in_req),
        .in_ack   (in_ack),
        .in_data  (in_data),
        .out_req  (out_req),
        .out_ack  (out_ack),
        .out_data (out_data)
    );

    function automatic logic [WIDTH-1:0] tok(input int i);
        return WIDTH'((i * 37 + 8'h3C) ^ (i >> 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [WIDTH-1:0] v);
        @(negedge clk);
        in_data = v;
        in_req  = 1'b1;
        do @(negedge clk); while (!in_ack);
        in_data = ~v;
        in_req  = 1'b0;
        do @(negedge clk); while (in_ack);
    endtask

    task automatic take(input logic [WIDTH-1:0] exp, input int stall, input string req);
        while (!out_req) @(negedge clk);
        for (int s = 0; s < stall; s++) @(negedge clk);
        chk(out_data == exp, req, out_data, exp);
        out_ack = 1'b1;
        do @(negedge clk); while (out_req);
        out_ack = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(in_ack == 1'b0, "R1 in_ack", in_ack, 0);
        chk(out_req == 1'b0, "R1 out_req", out_req, 0);
        chk(out_data == '0, "R1 out_data", out_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ack == 1'b0 && out_req == 1'b0, "R1 after release", {in_ack, out_req}, 0);
    endtask

    task automatic t_latency;
        int cnt;
        @(negedge clk);
        in_data = 8'hA5;
        in_req  = 1'b1;
        @(negedge clk);
        chk(in_ack == 1'b1, "R5 in_ack one edge", in_ack, 1);
        cnt = 1;
        while (!out_req && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        // R2: one cell step per edge gives a latency of STAGES
        chk(cnt == STAGES, "R5 R2 out_req latency", cnt, STAGES);
        chk(out_data == 8'hA5, "R6 offered data", out_data, 8'hA5);
        in_req = 1'b0;
        for (int s = 0; s < 10; s++) @(negedge clk);
        chk(out_req == 1'b1, "R4 held while stalled", out_req, 1);
        chk(out_data == 8'hA5, "R6 stable while stalled", out_data, 8'hA5);
        out_ack = 1'b1;
        do @(negedge clk); while (out_req);
        out_ack = 1'b0;
        for (int s = 0; s < 2 * STAGES; s++) @(negedge clk);
        chk(in_ack == 1'b0 && out_req == 1'b0, "R7 empty after drain", {in_ack, out_req}, 0);
    endtask

    task automatic t_capacity;
        int acc = 0;
        for (int t = 0; t <= CAP; t++) begin
            int w = 0;
            @(negedge clk);
            in_data = tok(100 + t);
            in_req  = 1'b1;
            while (!in_ack && w < 2 * STAGES + 4) begin
                @(negedge clk);
                w++;
            end
            if (in_ack) acc++;
            in_req = 1'b0;
            while (in_ack) @(negedge clk);
        end
        chk(acc == CAP, "R8 tokens held while stalled", acc, CAP);
        for (int t = 0; t < CAP; t++) take(tok(100 + t), 2, "R7 R8 drain order");
        for (int s = 0; s < 3 * STAGES; s++) @(negedge clk);
        chk(out_req == 1'b0, "R7 no duplicate after drain", out_req, 0);
    endtask

    task automatic t_stream;
        int got = 0;
        fork
            begin
                for (int i = 0; i < NSTREAM; i++) put(tok(i));
            end
            begin
                for (int i = 0; i < NSTREAM; i++) begin
                    take(tok(i), (i * 7) % 5, "R7 stream order");
                    got++;
                end
            end
        join
        chk(got == NSTREAM, "R7 stream count", got, NSTREAM);
        for (int s = 0; s < 3 * STAGES; s++) @(negedge clk);
        chk(out_req == 1'b0 && in_ack == 1'b0, "R7 no extra token", {in_ack, out_req}, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_capacity();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule